// File: doc/BRIEF.md
# Watchdog Timer with Early-Warning Interrupt

This block is a register-mapped watchdog with five 16-bit registers: control, service, reset cause, interrupt control and a miscellaneous register. A main down-counter is decremented by a slow enable pulse (`tick`), which the surrounding logic produces at 2 Hz. If software does not service the watchdog in time, the counter reaches zero. The block then records a timeout cause and pulses a reset request. Software services the watchdog by writing 16'h5555 followed by 16'hAAAA to the service register.

A second counter, present when `PRE_EN` is 1, raises a maskable interrupt a programmable number of ticks before the main counter expires. The enable bit can be set once and cannot then be cleared. The interrupt configuration is accepted only on the first write after reset. A control write can also request a reset directly.

Top module: `tick_watchdog`

## Requirements
- R1: After reset the registers read as follows: control 16'h0030, service 16'h0000, reset cause 16'h0000, interrupt control 16'h0000 | PRE_DEF (default 16'h0004), and miscellaneous 16'h0001. After reset `irq` and `rst_req` are 0, and both counters are stopped.
- R2: The control register holds the timeout in bits [15:8], the external-assert bit in bit 5, the software-reset bit in bit 4 and enable in bit 2. Bit 4 always reads 1, and the other bits read 0. Once enable holds 1, writes cannot clear it until the next reset.
- R3: A control write that leaves enable at 1 with a nonzero timeout T loads the main counter with T+1. The counter decrements on each `tick`. On the tick that takes it to zero, it stops and, one cycle later, `rst_req` is high for a cycle and the reset-cause register reads 16'h0002.
- R4: While enable is 0, or while the timeout field is 0, the main counter does not run, and ticks never cause `rst_req`.
- R5: A write of 16'hAAAA to the service register (offset 0x2) reloads the main counter with T+1, but only while the register holds 16'h5555. Every other service write only stores its value, which then reads back.
- R6: A control write with bit 4 at 0 makes the reset-cause register read 16'h0001. The register keeps only the most recent cause: 16'h0001 for a software request, 16'h0002 for a timeout.
- R7: A control write pulses `rst_req` in the next cycle in either of two cases: bits 5 and 4 are both written 0, or the resulting enable is 1 while the written timeout is 0.
- R8: The interrupt-control register has enable in bit 15, status in bit 14 and the pretimeout value P in bits [7:0]. When a start event occurs with the watchdog running and interrupt enable set, the early counter is loaded with (main count − P), but only if the main count is strictly greater than P. When that counter reaches zero, status sets and `irq` rises one cycle later.
- R9: Writing 1 to bit 14 of the interrupt-control register clears the status and lowers `irq`.
- R10: Only the first interrupt-control write after reset changes P and interrupt enable. Later writes can only clear the status.
- R11: Only bit 0 of the miscellaneous register (offset 0x8) can be written. Writes to the reset-cause register (offset 0x4) are ignored. Offsets without a register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Half-second enable pulse, one cycle wide |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Byte offset of the register |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data for `bus_addr` (combinational) |
| irq | output | 1 | Early-warning interrupt level |
| rst_req | output | 1 | Reset request pulse |

## Verification
The assertions assume that a register write lasts one cycle and that `bus_addr` selects a single register. Under that assumption a control, interrupt-control or service write always takes priority over a `tick` in the same cycle. The assertions also assume that `tick` is a clean single-cycle enable. The stimulus drives every bus write as a one-cycle strobe with a legal offset, and drives ticks as isolated pulses. The bench's reference model applies the same write-before-tick priority on every clock.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int REG_W  = 16;
  localparam int ADDR_W = 4;
  localparam int TMO_W  = 8;
  localparam int CNT_W  = TMO_W + 1;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 4'h0;
  localparam logic [ADDR_W-1:0] OFS_SVC  = 4'h2;
  localparam logic [ADDR_W-1:0] OFS_CAUS = 4'h4;
  localparam logic [ADDR_W-1:0] OFS_ICR  = 4'h6;
  localparam logic [ADDR_W-1:0] OFS_MISC = 4'h8;

  localparam int CB_EN  = 2;
  localparam int CB_SRS = 4;
  localparam int CB_EXT = 5;
  localparam int IB_ST  = 14;
  localparam int IB_IE  = 15;

  localparam logic [REG_W-1:0] SVC_FIRST  = 16'h5555;
  localparam logic [REG_W-1:0] SVC_SECOND = 16'hAAAA;

  typedef enum logic [1:0] {
    CAUSE_NONE = 2'd0,
    CAUSE_SW   = 2'd1,
    CAUSE_TOUT = 2'd2
  } cause_e;

  function automatic logic [CNT_W-1:0] reload_of(input logic [TMO_W-1:0] t);
    return {1'b0, t} + CNT_W'(1);
  endfunction

  function automatic logic pre_fits(input logic [CNT_W-1:0] c, input logic [TMO_W-1:0] p);
    return c > {1'b0, p};
  endfunction

  function automatic logic [CNT_W-1:0] pre_start(input logic [CNT_W-1:0] c, input logic [TMO_W-1:0] p);
    return c - {1'b0, p};
  endfunction
endpackage

// File: rtl/wdt_down_cnt.sv
module wdt_down_cnt #(
  parameter int W = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         stop,
  input  logic         load,
  input  logic         start,
  input  logic [W-1:0] value,
  input  logic         tick,
  output logic [W-1:0] cnt,
  output logic         act,
  output logic         fire
);
  logic touched;
  assign touched = stop | load | start;
  assign fire    = !touched && tick && act && (cnt == W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      act <= 1'b0;
    end else if (touched) begin
      if (load) cnt <= value;
      if (start) act <= 1'b1;
      else if (stop) act <= 1'b0;
    end else if (tick && act) begin
      cnt <= cnt - W'(1);
      if (cnt == W'(1)) act <= 1'b0;
    end
  end
endmodule

// File: rtl/wdt_svc_seq.sv
module wdt_svc_seq
  import wdt_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [REG_W-1:0] wdata,
  output logic [REG_W-1:0] stored,
  output logic             match
);
  assign match = wr && (stored == SVC_FIRST) && (wdata == SVC_SECOND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stored <= '0;
    else if (wr) stored <= wdata;
  end
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
  import wdt_pkg::*;
#(
  parameter bit               PRE_EN  = 1'b1,
  parameter logic [TMO_W-1:0] PRE_DEF = 8'd4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq,
  output logic              rst_req
);
  logic wr_ctrl, wr_svc, wr_icr, wr_misc;
  assign wr_ctrl = bus_we && (bus_addr == OFS_CTRL);
  assign wr_svc  = bus_we && (bus_addr == OFS_SVC);
  assign wr_icr  = bus_we && (bus_addr == OFS_ICR) && PRE_EN;
  assign wr_misc = bus_we && (bus_addr == OFS_MISC);

  logic [TMO_W-1:0] ctrl_tmo_q;
  logic             ctrl_ext_q, ctrl_en_q, misc_pde_q;
  logic [TMO_W-1:0] icr_pre_q;
  logic             icr_ie_q, icr_st_q, icr_lock_q;
  cause_e           cause_q;
  logic             rst_req_q;

  // effective control values for this write
  logic [TMO_W-1:0] tmo_new;
  logic             en_new, cfg_new, cfg_now, ctrl_req;
  assign tmo_new  = bus_wdata[REG_W-1 -: TMO_W];
  assign en_new   = ctrl_en_q | bus_wdata[CB_EN];
  assign cfg_new  = en_new && (tmo_new != '0);
  assign cfg_now  = ctrl_en_q && (ctrl_tmo_q != '0);
  assign ctrl_req = wr_ctrl && ((!bus_wdata[CB_EXT] && !bus_wdata[CB_SRS]) ||
                                (en_new && (tmo_new == '0)));

  logic [REG_W-1:0] svc_q;
  logic             svc_match;
  wdt_svc_seq u_svc (
    .clk(clk), .rst_n(rst_n), .wr(wr_svc), .wdata(bus_wdata),
    .stored(svc_q), .match(svc_match)
  );

  logic [CNT_W-1:0] main_cnt;
  logic             main_act, main_fire;
  wdt_down_cnt #(.W(CNT_W)) u_main (
    .clk(clk), .rst_n(rst_n),
    .stop(wr_ctrl),
    .load((wr_ctrl && cfg_new) || (svc_match && cfg_now)),
    .start(wr_ctrl && cfg_new),
    .value(wr_ctrl ? reload_of(tmo_new) : reload_of(ctrl_tmo_q)),
    .tick(tick),
    .cnt(main_cnt), .act(main_act), .fire(main_fire)
  );

  // early-warning counter inputs
  logic [TMO_W-1:0] pre_new;
  logic             ie_new;
  assign pre_new = icr_lock_q ? icr_pre_q : bus_wdata[TMO_W-1:0];
  assign ie_new  = icr_lock_q ? icr_ie_q  : bus_wdata[IB_IE];

  logic [CNT_W-1:0] p_base;
  logic [TMO_W-1:0] p_pre;
  logic             p_cfg, p_ie, p_ok, p_ev, p_start_ev;
  always_comb begin
    p_base = reload_of(ctrl_tmo_q);
    p_pre  = icr_pre_q;
    p_cfg  = cfg_now;
    p_ie   = icr_ie_q;
    if (wr_ctrl) begin
      p_base = reload_of(tmo_new);
      p_cfg  = cfg_new;
    end else if (wr_icr) begin
      p_base = main_cnt;
      p_pre  = pre_new;
      p_ie   = ie_new;
    end
  end
  assign p_ok       = p_cfg && p_ie && pre_fits(p_base, p_pre);
  assign p_start_ev = wr_ctrl || wr_icr;
  assign p_ev       = p_start_ev || svc_match;

  logic pre_fire;
  generate
    if (PRE_EN) begin : g_pre
      logic [CNT_W-1:0] pre_cnt;
      logic             pre_act;
      wdt_down_cnt #(.W(CNT_W)) u_pre (
        .clk(clk), .rst_n(rst_n),
        .stop(p_start_ev || (svc_match && !icr_ie_q)),
        .load(p_ev && p_ok),
        .start(p_start_ev && p_ok),
        .value(pre_start(p_base, p_pre)),
        .tick(tick),
        .cnt(pre_cnt), .act(pre_act), .fire(pre_fire)
      );
    end else begin : g_nopre
      assign pre_fire = 1'b0;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_tmo_q <= '0;
      ctrl_ext_q <= 1'b1;
      ctrl_en_q  <= 1'b0;
      misc_pde_q <= 1'b1;
      icr_pre_q  <= PRE_DEF;
      icr_ie_q   <= 1'b0;
      icr_st_q   <= 1'b0;
      icr_lock_q <= 1'b0;
      cause_q    <= CAUSE_NONE;
      rst_req_q  <= 1'b0;
    end else begin
      rst_req_q <= ctrl_req || main_fire;
      if (wr_ctrl) begin
        ctrl_tmo_q <= tmo_new;
        ctrl_ext_q <= bus_wdata[CB_EXT];
        ctrl_en_q  <= en_new;
      end
      if (wr_ctrl && !bus_wdata[CB_SRS]) cause_q <= CAUSE_SW;
      else if (main_fire)                cause_q <= CAUSE_TOUT;
      if (wr_icr) begin
        icr_pre_q  <= pre_new;
        icr_ie_q   <= ie_new;
        icr_lock_q <= 1'b1;
        if (bus_wdata[IB_ST]) icr_st_q <= 1'b0;
      end
      if (pre_fire) icr_st_q <= 1'b1;
      if (wr_misc) misc_pde_q <= bus_wdata[0];
    end
  end

  always_comb begin
    case (bus_addr)
      OFS_CTRL: bus_rdata = {ctrl_tmo_q, 2'b00, ctrl_ext_q, 1'b1, 1'b0, ctrl_en_q, 2'b00};
      OFS_SVC:  bus_rdata = svc_q;
      OFS_CAUS: bus_rdata = {14'd0, cause_q};
      OFS_ICR:  bus_rdata = {icr_ie_q, icr_st_q, 6'd0, icr_pre_q};
      OFS_MISC: bus_rdata = {15'd0, misc_pde_q};
      default:  bus_rdata = '0;
    endcase
  end

  assign irq     = icr_st_q;
  assign rst_req = rst_req_q;
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
  parameter int CW = 9,
  parameter int PW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rst_req,
  input logic          irq,
  input logic          main_fire,
  input logic          pre_fire,
  input logic          main_act,
  input logic [CW-1:0] main_cnt,
  input logic          en_q,
  input logic          icr_lock,
  input logic [PW-1:0] icr_pre,
  input logic          icr_ie,
  input logic [1:0]    cause
);
  // R3
  expire_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_fire |=> rst_req);
  // R3
  expire_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_fire |=> (cause == 2'd2));
  // R3
  live_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    main_act |-> (main_cnt != '0));
  // R4
  idle_no_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !main_act |-> !main_fire);
  // R2
  en_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_q |=> en_q);
  // R10
  icr_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    icr_lock |=> ($stable(icr_pre) && $stable(icr_ie)));
  // R8
  irq_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(pre_fire));
endmodule

bind tick_watchdog wdt_checker #(.CW(wdt_pkg::CNT_W), .PW(wdt_pkg::TMO_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rst_req(rst_req), .irq(irq),
  .main_fire(main_fire), .pre_fire(pre_fire), .main_act(main_act),
  .main_cnt(main_cnt), .en_q(ctrl_en_q), .icr_lock(icr_lock_q),
  .icr_pre(icr_pre_q), .icr_ie(icr_ie_q), .cause(cause_q)
);

// File: tb/sim_tick_watchdog.sv
module sim_tick_watchdog;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        bus_we = 1'b0;
  logic [3:0]  bus_addr = 4'h0;
  logic [15:0] bus_wdata = 16'h0;
  logic [15:0] bus_rdata;
  logic        irq, rst_req;

  int total = 0;
  int bad = 0;
  bit done = 0;
  string cur_req = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  tick_watchdog u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq(irq), .rst_req(rst_req)
  );

  // ---------------- reference model ----------------
  int m_tmo, m_ext, m_en, m_svc, m_cause, m_pre, m_ie, m_st, m_lock, m_pde;
  int m_cnt, m_act, p_cnt, p_act, m_req;

  task automatic model_reset();
    m_tmo = 0; m_ext = 1; m_en = 0; m_svc = 0; m_cause = 0;
    m_pre = 4; m_ie = 0; m_st = 0; m_lock = 0; m_pde = 1;
    m_cnt = 0; m_act = 0; p_cnt = 0; p_act = 0; m_req = 0;
  endtask

  function automatic int model_read(input logic [3:0] a);
    case (a)
      4'h0: return (m_tmo << 8) | (m_ext << 5) | 16 | (m_en << 2);
      4'h2: return m_svc;
      4'h4: return m_cause;
      4'h6: return (m_ie << 15) | (m_st << 14) | m_pre;
      4'h8: return m_pde;
      default: return 0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (!rst_n) model_reset();
    else begin
      int d, mt, pt, req, base, cfg, ie, pre, nen, ntmo;
      d = bus_wdata; mt = 0; pt = 0; req = 0;
      cfg = (m_en != 0 && m_tmo != 0);
      if (bus_we && bus_addr == 4'h0) begin
        nen = m_en | ((d >> 2) & 1); ntmo = (d >> 8) & 255;
        if (((d >> 5) & 1) == 0 && ((d >> 4) & 1) == 0) req = 1;
        if (nen == 1 && ntmo == 0) req = 1;
        if (((d >> 4) & 1) == 0) m_cause = 1;
        m_en = nen; m_tmo = ntmo; m_ext = (d >> 5) & 1;
        cfg = (m_en != 0 && m_tmo != 0);
        mt = 1; m_act = 0;
        if (cfg) begin m_cnt = m_tmo + 1; m_act = 1; end
        pt = 1; p_act = 0;
        if (cfg && m_ie != 0 && m_cnt > m_pre) begin p_cnt = m_cnt - m_pre; p_act = 1; end
      end else if (bus_we && bus_addr == 4'h6) begin
        if (m_lock == 0) begin m_pre = d & 255; m_ie = (d >> 15) & 1; end
        m_lock = 1;
        if ((d >> 14) & 1) m_st = 0;
        pt = 1; p_act = 0;
        if (cfg && m_ie != 0 && m_cnt > m_pre) begin p_cnt = m_cnt - m_pre; p_act = 1; end
      end else if (bus_we && bus_addr == 4'h2) begin
        if (m_svc == 16'h5555 && d == 16'hAAAA) begin
          if (cfg) begin m_cnt = m_tmo + 1; mt = 1; end
          if (m_ie == 0) begin p_act = 0; pt = 1; end
          else if (cfg && (m_tmo + 1) > m_pre) begin p_cnt = m_tmo + 1 - m_pre; pt = 1; end
        end
        m_svc = d;
      end else if (bus_we && bus_addr == 4'h8) begin
        m_pde = d & 1;
      end
      if (!mt && tick && m_act != 0) begin
        if (m_cnt == 1) begin m_cnt = 0; m_act = 0; m_cause = 2; req = 1; end
        else m_cnt = m_cnt - 1;
      end
      if (!pt && tick && p_act != 0) begin
        if (p_cnt == 1) begin p_cnt = 0; p_act = 0; m_st = 1; end
        else p_cnt = p_cnt - 1;
      end
      m_req = req;
    end
  end

  task automatic check(input string tag, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h at %0t", tag, got, exp, $time);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({cur_req, " rst_req"}, int'(rst_req), m_req);
      check({cur_req, " irq"}, int'(irq), m_st);
      check({cur_req, " rdata"}, int'(bus_rdata), model_read(bus_addr));
    end
  end

  task automatic step(input logic w, input logic [3:0] a, input logic [15:0] d, input logic t);
    @(negedge clk); #1;
    bus_we = w; bus_addr = a; bus_wdata = d; tick = t;
    @(posedge clk); #1;
    bus_we = 1'b0; tick = 1'b0;
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    step(1'b1, a, d, 1'b0);
  endtask

  task automatic tk();
    step(1'b0, bus_addr, 16'h0, 1'b1);
  endtask

  task automatic rd(input logic [3:0] a, input int exp, input string tag);
    @(negedge clk); #1;
    bus_addr = a;
    #1 check(tag, int'(bus_rdata), exp);
  endtask

  task automatic ticks_to_req(input int exp, input string tag);
    int n = 0;
    for (int i = 0; i < 300; i++) begin
      tk();
      n++;
      if (rst_req) break;
    end
    check(tag, n, exp);
  endtask

  task automatic do_reset();
    @(negedge clk); #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;

    cur_req = "R1";
    rd(4'h0, 16'h0030, "R1 ctrl");
    rd(4'h2, 16'h0000, "R1 svc");
    rd(4'h4, 16'h0000, "R1 cause");
    rd(4'h6, 16'h0004, "R1 icr");
    rd(4'h8, 16'h0001, "R1 misc");
    check("R1 irq", int'(irq), 0);
    check("R1 rst_req", int'(rst_req), 0);

    cur_req = "R11";
    wr(4'h4, 16'hFFFF);
    rd(4'h4, 16'h0000, "R11 cause ignores writes");
    wr(4'h8, 16'hFFFF);
    rd(4'h8, 16'h0001, "R11 misc bit0 only");
    wr(4'h8, 16'h0000);
    rd(4'h8, 16'h0000, "R11 misc clear");
    rd(4'hA, 16'h0000, "R11 unmapped");

    cur_req = "R2";
    wr(4'h0, 16'h0338);
    rd(4'h0, 16'h0330, "R2 ctrl fields");

    cur_req = "R4";
    for (int i = 0; i < 5; i++) begin
      tk();
      check("R4 no request while disabled", int'(rst_req), 0);
    end
    rd(4'h4, 16'h0000, "R4 cause");

    cur_req = "R7";
    wr(4'h0, 16'h0000);
    check("R7 ext and srs low", int'(rst_req), 1);
    cur_req = "R6";
    rd(4'h4, 16'h0001, "R6 software cause");

    cur_req = "R10";
    wr(4'h6, 16'h8002);
    wr(4'h6, 16'h0005);
    rd(4'h6, 16'h8002, "R10 config locked");

    cur_req = "R8";
    wr(4'h0, 16'h0534);
    for (int i = 0; i < 3; i++) tk();
    check("R8 irq not yet", int'(irq), 0);
    tk();
    check("R8 irq at main minus pre", int'(irq), 1);

    cur_req = "R9";
    wr(4'h6, 16'h4000);
    check("R9 irq cleared", int'(irq), 0);

    cur_req = "R5";
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'hAAAA);
    wr(4'h2, 16'hAAAA);
    rd(4'h2, 16'hAAAA, "R5 svc stored");
    tk();
    wr(4'h2, 16'h5555);
    wr(4'h2, 16'h1234);
    wr(4'h2, 16'hAAAA);
    ticks_to_req(5, "R5 only proper sequence reloads");

    cur_req = "R3";
    rd(4'h4, 16'h0002, "R3 timeout cause");

    cur_req = "R2";
    wr(4'h0, 16'h0030);
    cur_req = "R7";
    check("R7 enable with zero timeout", int'(rst_req), 1);
    cur_req = "R2";
    rd(4'h0, 16'h0034, "R2 enable sticky");

    cur_req = "R1";
    do_reset();
    rd(4'h0, 16'h0030, "R1 ctrl after reset");
    rd(4'h6, 16'h0004, "R1 icr after reset");
    rd(4'h4, 16'h0000, "R1 cause after reset");

    cur_req = "R8";
    wr(4'h6, 16'h8007);
    wr(4'h0, 16'h0634);
    cur_req = "R3";
    ticks_to_req(7, "R3 expiry after T+1 ticks");
    check("R8 no irq when main not above pre", int'(irq), 0);
    tk();
    check("R3 single pulse", int'(rst_req), 0);

    cur_req = "R6";
    wr(4'h0, 16'h0624);
    rd(4'h4, 16'h0001, "R6 latest cause kept");
    cur_req = "R3";
    ticks_to_req(7, "R3 restart after control write");

    repeat (3) @(negedge clk);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule